// File: doc/BRIEF.md
# Multi-Channel DMA Control Register Bank

This block is the register front end of a descriptor-driven DMA controller with `NUM_CH` channels. A 32-bit word bus reaches it. Every channel owns an 8 KB address frame. Inside the frame, a small set of word registers holds the channel's descriptor pointers, group pointers, configuration, command words and interrupt state. The transfer engines that walk descriptors and move data sit outside the block. They receive one-cycle request pulses from it: load descriptor, start, load context and continue. They return the live flags that the status word and the continue check need, together with interrupt events and the context fields they have fetched.

Writes to the two command registers turn into engine requests. The stream-command word starts descriptor and context loads. The plain command word asks the engine to continue a list that has stopped on an end-of-list descriptor. The block stores each channel's raw interrupt events, applies a software mask and drives one registered interrupt line per channel. Bus responses are registered. An access that is not a whole, aligned word is refused with an error and changes nothing.

Top module: `dma_chan_regs`

## Requirements
- R1: The channel is selected by address bits [ADDR_W-1:13] and the register word by address bits [7:2]. An access whose bits [12:8] are not zero falls in a hole: it reads zero and writes nothing, with no error.
- R2: The registers at offsets 0x00 (current descriptor), 0x58 (saved descriptor pointer), 0x5C (saved buffer pointer), 0x60 (group), 0x7C (group-down), 0x80 (command), 0x84 (config) and 0x9C (stream command) read back the last 32-bit value written. Offset 0x8C (mask) keeps only its low IRQ_W bits. Offsets that are not defined read zero.
- R3: After reset every channel is in state RESET. In the one-hot state code RESET=1, STOPPED=2 and RUNNING=4. A config write with bit 1 set moves the state to STOPPED. A config write with bit 0 clear then moves it to RESET, and this takes priority. Any other config write leaves the state unchanged.
- R4: A read at offset 0x88 returns the state in bits [2:0], the engine's channel end-of-list flag in bit 5 and the engine's 8-bit stream source in bits [15:8]. All other bits read zero.
- R5: A write to offset 0x90 clears the raw interrupt bits that are set in the written value. An engine event in the same cycle still sets its bit. Offset 0x90 always reads zero, and offset 0x94 returns the raw bits.
- R6: Offset 0x98 returns raw AND mask. The channel's `irq` output goes high when that value is non-zero, and it is updated on the same clock edge as the registers it depends on.
- R7: Only bits [9:0] of a stream-command write are decoded. If (value & 0x140) is non-zero, a descriptor load is requested with `req_desc_addr` set to the saved descriptor pointer, and that pointer is copied into offset 0x00. If bit 0x20 is also set, `req_start` pulses and the state becomes RUNNING. Bit 0x20 alone requests nothing.
- R8: If (value & 0x200) is non-zero, a context load is requested with `req_ctx_addr` set to the group-down register. A returned context (`eng_ctx_valid`) writes its two fields into offsets 0x58 and 0x5C of the addressed channel, and it wins over a bus write to them in the same cycle.
- R9: A command write requests a continue only when config bit 0 is set, config bit 1 is clear, the state is RUNNING and the engine reports that the current descriptor has end-of-list set.
- R10: `bad_store` pulses for a command write with any of bits [31:1] set, or for a stream-command write with any of bits [31:10] set. The value is still stored.
- R11: An access with `bus_size` other than 2'b10 (word), or with address bits [1:0] not zero, returns `bus_err` with zero read data, leaves all registers unchanged and issues no request.
- R12: Every access is answered by `bus_ack` one cycle after it is presented. `bus_rdata`, `bus_err`, `bad_store` and the request outputs all appear in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access presented this cycle |
| bus_write | input | 1 | 1 write, 0 read |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word |
| bus_addr | input | ADDR_W | Byte address (channel frame and offset) |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | Access response |
| bus_err | output | 1 | Access refused |
| bus_rdata | output | 32 | Read data |
| bad_store | output | 1 | Command word carried reserved bits |
| eng_eol | input | NUM_CH | Channel end-of-list flag per channel |
| eng_desc_eol | input | NUM_CH | Current descriptor has end-of-list set |
| eng_src | input | 8*NUM_CH | Stream source per channel |
| eng_irq_set | input | IRQ_W*NUM_CH | Interrupt event pulses per channel |
| eng_ctx_valid | input | 1 | Context fields returned |
| eng_ctx_ch | input | CH_W | Channel of returned context |
| eng_ctx_data | input | 32 | Returned saved descriptor pointer |
| eng_ctx_buf | input | 32 | Returned saved buffer pointer |
| req_valid | output | 1 | An engine request is present |
| req_ch | output | CH_W | Requesting channel |
| req_load_d | output | 1 | Load descriptor |
| req_start | output | 1 | Start channel |
| req_load_c | output | 1 | Load context |
| req_cont | output | 1 | Continue channel |
| req_desc_addr | output | 32 | Descriptor address for the load |
| req_ctx_addr | output | 32 | Context address for the load |
| irq | output | NUM_CH | Interrupt line per channel |

## Verification
The hardest state to reach is a continue request that is actually honoured. It needs four things at once: the channel must be RUNNING, which only a stream-command start can cause; the config must read enabled and not stopped; the engine must report end-of-list on the current descriptor; and then a command write must arrive. The bench sets these up in order on one channel and then removes them one at a time, checking each time that the request disappears. It also runs the config-write corner where bit 1 is set and bit 0 is clear, which must end in RESET and not STOPPED. Random register traffic with a fixed seed goes to all channels and is checked against a bench model, so a write that lands in the wrong frame or register shows up.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int WORD_W = 32;
  localparam int IDX_W  = 6;
  localparam int SRC_W  = 8;

  localparam logic [IDX_W-1:0] IDX_DESC   = 6'd0;
  localparam logic [IDX_W-1:0] IDX_SAVED  = 6'd22;
  localparam logic [IDX_W-1:0] IDX_SBUF   = 6'd23;
  localparam logic [IDX_W-1:0] IDX_GROUP  = 6'd24;
  localparam logic [IDX_W-1:0] IDX_GDOWN  = 6'd31;
  localparam logic [IDX_W-1:0] IDX_CMD    = 6'd32;
  localparam logic [IDX_W-1:0] IDX_CFG    = 6'd33;
  localparam logic [IDX_W-1:0] IDX_STAT   = 6'd34;
  localparam logic [IDX_W-1:0] IDX_MASK   = 6'd35;
  localparam logic [IDX_W-1:0] IDX_ACK    = 6'd36;
  localparam logic [IDX_W-1:0] IDX_RAW    = 6'd37;
  localparam logic [IDX_W-1:0] IDX_MSKD   = 6'd38;
  localparam logic [IDX_W-1:0] IDX_STREAM = 6'd39;

  localparam logic [9:0] SC_LOAD_D = 10'h140;
  localparam logic [9:0] SC_BURST  = 10'h020;
  localparam logic [9:0] SC_LOAD_C = 10'h200;

  localparam logic [1:0] SZ_WORD = 2'b10;

  typedef enum logic [2:0] {
    ST_RESET = 3'b001,
    ST_STOP  = 3'b010,
    ST_RUN   = 3'b100
  } chan_state_e;

  typedef struct packed {
    logic load_d;
    logic start;
    logic load_c;
    logic cont;
  } chan_req_t;
endpackage

// File: rtl/dma_bus_decode.sv
module dma_bus_decode
  import dma_chan_pkg::*;
#(
  parameter int CH_W   = 2,
  parameter int ADDR_W = 15
) (
  input  logic              valid,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  output logic              acc_ok,
  output logic              acc_err,
  output logic              in_win,
  output logic [CH_W-1:0]   ch,
  output logic [IDX_W-1:0]  idx
);
  logic aligned;

  always_comb begin
    aligned = (addr[1:0] == 2'b00);
    acc_ok  = valid && (size == SZ_WORD) && aligned;
    acc_err = valid && !acc_ok;
    in_win  = (addr[12:8] == 5'd0);
    ch      = addr[ADDR_W-1:13];
    idx     = addr[7:2];
  end
endmodule

// File: rtl/dma_chan_irq.sv
module dma_chan_irq #(
  parameter int IRQ_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mask_we,
  input  logic             ack_we,
  input  logic [IRQ_W-1:0] wbits,
  input  logic [IRQ_W-1:0] set_i,
  output logic [IRQ_W-1:0] raw_q,
  output logic [IRQ_W-1:0] mask_q,
  output logic             irq_q
);
  logic [IRQ_W-1:0] raw_d;
  logic [IRQ_W-1:0] mask_d;

  always_comb begin
    raw_d  = (raw_q & ~(ack_we ? wbits : '0)) | set_i;
    mask_d = mask_we ? wbits : mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q  <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      raw_q  <= raw_d;
      mask_q <= mask_d;
      irq_q  <= |(raw_d & mask_d);
    end
  end

  // R5: acknowledged bits are gone on the next edge when no event competes
  a_r5_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (ack_we && set_i == '0) |=> ((raw_q & $past(wbits)) == '0));

  // R6: a full acknowledge with no new event drops the line
  a_r6_ack_drops_irq: assert property (@(posedge clk) disable iff (rst)
    (ack_we && (&wbits) && set_i == '0) |=> !irq_q);
endmodule

// File: rtl/dma_chan_slice.sv
module dma_chan_slice
  import dma_chan_pkg::*;
#(
  parameter int IRQ_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] wdata,
  input  logic              desc_eol_i,
  input  logic              eol_i,
  input  logic [SRC_W-1:0]  src_i,
  input  logic [IRQ_W-1:0]  irq_set_i,
  input  logic              ctx_we,
  input  logic [WORD_W-1:0] ctx_data,
  input  logic [WORD_W-1:0] ctx_buf,
  output logic [WORD_W-1:0] rd_data,
  output chan_req_t         req_q,
  output logic [WORD_W-1:0] desc_addr_q,
  output logic [WORD_W-1:0] ctx_addr_q,
  output logic              irq_o
);
  logic [WORD_W-1:0] desc_q, saved_q, sbuf_q, group_q, gdown_q;
  logic [WORD_W-1:0] cmd_q, cfg_q, stream_q;
  chan_state_e       state_q;
  logic [IRQ_W-1:0]  raw_q, mask_q;

  logic sc_ld, sc_st, sc_lc, cont_ok;
  logic we_stream, we_cmd, we_cfg;

  always_comb begin
    we_stream = wr_en && (idx == IDX_STREAM);
    we_cmd    = wr_en && (idx == IDX_CMD);
    we_cfg    = wr_en && (idx == IDX_CFG);
    sc_ld     = |(wdata[9:0] & SC_LOAD_D);
    sc_st     = sc_ld && |(wdata[9:0] & SC_BURST);
    sc_lc     = |(wdata[9:0] & SC_LOAD_C);
    cont_ok   = cfg_q[0] && !cfg_q[1] && (state_q == ST_RUN) && desc_eol_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      desc_q      <= '0;
      saved_q     <= '0;
      sbuf_q      <= '0;
      group_q     <= '0;
      gdown_q     <= '0;
      cmd_q       <= '0;
      cfg_q       <= '0;
      stream_q    <= '0;
      state_q     <= ST_RESET;
      req_q       <= '0;
      desc_addr_q <= '0;
      ctx_addr_q  <= '0;
    end else begin
      req_q <= '0;
      if (wr_en) begin
        case (idx)
          IDX_DESC:  desc_q  <= wdata;
          IDX_SAVED: saved_q <= wdata;
          IDX_SBUF:  sbuf_q  <= wdata;
          IDX_GROUP: group_q <= wdata;
          IDX_GDOWN: gdown_q <= wdata;
          default: ;
        endcase
      end
      if (we_cfg) begin
        cfg_q <= wdata;
        if (wdata[1])  state_q <= ST_STOP;
        if (!wdata[0]) state_q <= ST_RESET;
      end
      if (we_cmd) begin
        cmd_q      <= wdata;
        req_q.cont <= cont_ok;
      end
      if (we_stream) begin
        stream_q <= wdata;
        if (sc_ld) begin
          desc_q       <= saved_q;
          desc_addr_q  <= saved_q;
          req_q.load_d <= 1'b1;
        end
        if (sc_st) begin
          req_q.start <= 1'b1;
          state_q     <= ST_RUN;
        end
        if (sc_lc) begin
          ctx_addr_q   <= gdown_q;
          req_q.load_c <= 1'b1;
        end
      end
      if (ctx_we) begin
        saved_q <= ctx_data;
        sbuf_q  <= ctx_buf;
      end
    end
  end

  dma_chan_irq #(.IRQ_W(IRQ_W)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .mask_we (wr_en && (idx == IDX_MASK)),
    .ack_we  (wr_en && (idx == IDX_ACK)),
    .wbits   (wdata[IRQ_W-1:0]),
    .set_i   (irq_set_i),
    .raw_q   (raw_q),
    .mask_q  (mask_q),
    .irq_q   (irq_o)
  );

  always_comb begin
    case (idx)
      IDX_DESC:   rd_data = desc_q;
      IDX_SAVED:  rd_data = saved_q;
      IDX_SBUF:   rd_data = sbuf_q;
      IDX_GROUP:  rd_data = group_q;
      IDX_GDOWN:  rd_data = gdown_q;
      IDX_CMD:    rd_data = cmd_q;
      IDX_CFG:    rd_data = cfg_q;
      IDX_STAT:   rd_data = {16'd0, src_i, 2'd0, eol_i, 2'd0, state_q};
      IDX_MASK:   rd_data = WORD_W'(mask_q);
      IDX_RAW:    rd_data = WORD_W'(raw_q);
      IDX_MSKD:   rd_data = WORD_W'(raw_q & mask_q);
      IDX_STREAM: rd_data = stream_q;
      default:    rd_data = '0;
    endcase
  end

  // R3: the state register always holds exactly one legal code
  a_r3_state_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot(state_q));

  // R9: a continue only leaves while the channel was running and enabled
  a_r9_cont_gated: assert property (@(posedge clk) disable iff (rst)
    req_q.cont |-> ($past(state_q) == ST_RUN && $past(cfg_q[0]) && !$past(cfg_q[1])));

  // R7: a start comes with a descriptor load and leaves the channel running
  a_r7_start_runs: assert property (@(posedge clk) disable iff (rst)
    req_q.start |-> (req_q.load_d && state_q == ST_RUN));
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int IRQ_W  = 4,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = 13 + CH_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bus_valid,
  input  logic                    bus_write,
  input  logic [1:0]              bus_size,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [31:0]             bus_wdata,
  output logic                    bus_ack,
  output logic                    bus_err,
  output logic [31:0]             bus_rdata,
  output logic                    bad_store,
  input  logic [NUM_CH-1:0]       eng_eol,
  input  logic [NUM_CH-1:0]       eng_desc_eol,
  input  logic [8*NUM_CH-1:0]     eng_src,
  input  logic [IRQ_W*NUM_CH-1:0] eng_irq_set,
  input  logic                    eng_ctx_valid,
  input  logic [CH_W-1:0]         eng_ctx_ch,
  input  logic [31:0]             eng_ctx_data,
  input  logic [31:0]             eng_ctx_buf,
  output logic                    req_valid,
  output logic [CH_W-1:0]         req_ch,
  output logic                    req_load_d,
  output logic                    req_start,
  output logic                    req_load_c,
  output logic                    req_cont,
  output logic [31:0]             req_desc_addr,
  output logic [31:0]             req_ctx_addr,
  output logic [NUM_CH-1:0]       irq
);
  logic              acc_ok, acc_err, in_win;
  logic [CH_W-1:0]   ch;
  logic [IDX_W-1:0]  idx;
  logic              wr_any;

  logic [WORD_W-1:0] rd_vec    [NUM_CH];
  chan_req_t         req_vec   [NUM_CH];
  logic [WORD_W-1:0] daddr_vec [NUM_CH];
  logic [WORD_W-1:0] caddr_vec [NUM_CH];
  logic [NUM_CH-1:0] req_any;

  dma_bus_decode #(.CH_W(CH_W), .ADDR_W(ADDR_W)) u_dec (
    .valid   (bus_valid),
    .size    (bus_size),
    .addr    (bus_addr),
    .acc_ok  (acc_ok),
    .acc_err (acc_err),
    .in_win  (in_win),
    .ch      (ch),
    .idx     (idx)
  );

  assign wr_any = acc_ok && bus_write && in_win;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dma_chan_slice #(.IRQ_W(IRQ_W)) u_slice (
      .clk         (clk),
      .rst         (rst),
      .wr_en       (wr_any && (ch == CH_W'(c))),
      .idx         (idx),
      .wdata       (bus_wdata),
      .desc_eol_i  (eng_desc_eol[c]),
      .eol_i       (eng_eol[c]),
      .src_i       (eng_src[8*c +: 8]),
      .irq_set_i   (eng_irq_set[IRQ_W*c +: IRQ_W]),
      .ctx_we      (eng_ctx_valid && (eng_ctx_ch == CH_W'(c))),
      .ctx_data    (eng_ctx_data),
      .ctx_buf     (eng_ctx_buf),
      .rd_data     (rd_vec[c]),
      .req_q       (req_vec[c]),
      .desc_addr_q (daddr_vec[c]),
      .ctx_addr_q  (caddr_vec[c]),
      .irq_o       (irq[c])
    );
    assign req_any[c] = |req_vec[c];
  end

  always_comb begin
    req_valid     = 1'b0;
    req_ch        = '0;
    req_load_d    = 1'b0;
    req_start     = 1'b0;
    req_load_c    = 1'b0;
    req_cont      = 1'b0;
    req_desc_addr = '0;
    req_ctx_addr  = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (req_any[c]) begin
        req_valid     = 1'b1;
        req_ch        = CH_W'(c);
        req_load_d    = req_vec[c].load_d;
        req_start     = req_vec[c].start;
        req_load_c    = req_vec[c].load_c;
        req_cont      = req_vec[c].cont;
        req_desc_addr = daddr_vec[c];
        req_ctx_addr  = caddr_vec[c];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_ack   <= 1'b0;
      bus_err   <= 1'b0;
      bus_rdata <= '0;
      bad_store <= 1'b0;
    end else begin
      bus_ack   <= bus_valid;
      bus_err   <= acc_err;
      bus_rdata <= (acc_ok && !bus_write && in_win) ? rd_vec[ch] : '0;
      bad_store <= wr_any && (((idx == IDX_CMD) && |bus_wdata[31:1]) ||
                              ((idx == IDX_STREAM) && |bus_wdata[31:10]));
    end
  end

  // R11: a refused access never produces an engine request
  a_r11_err_quiet: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> !req_valid);

  // R1: one bus access reaches at most one channel
  a_r1_single_channel: assert property (@(posedge clk) disable iff (rst)
    $onehot0(req_any));

  // R12: every response follows a presented access
  a_r12_ack_follows: assert property (@(posedge clk) disable iff (rst)
    bus_ack |-> $past(bus_valid));
endmodule

// File: tb/dma_chan_regs_test.sv
module dma_chan_regs_test;
  localparam int NUM_CH = 4;
  localparam int IRQ_W  = 4;
  localparam int CH_W   = 2;
  localparam int ADDR_W = 15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [1:0] bus_size = 2'b10;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_ack, bus_err, bad_store;
  logic [31:0] bus_rdata;
  logic [NUM_CH-1:0] eng_eol = '0, eng_desc_eol = '0;
  logic [8*NUM_CH-1:0] eng_src = '0;
  logic [IRQ_W*NUM_CH-1:0] eng_irq_set = '0;
  logic eng_ctx_valid = 1'b0;
  logic [CH_W-1:0] eng_ctx_ch = '0;
  logic [31:0] eng_ctx_data = '0, eng_ctx_buf = '0;
  logic req_valid, req_load_d, req_start, req_load_c, req_cont;
  logic [CH_W-1:0] req_ch;
  logic [31:0] req_desc_addr, req_ctx_addr;
  logic [NUM_CH-1:0] irq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dma_chan_regs #(.NUM_CH(NUM_CH), .IRQ_W(IRQ_W)) uut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata),
    .bad_store(bad_store), .eng_eol(eng_eol), .eng_desc_eol(eng_desc_eol),
    .eng_src(eng_src), .eng_irq_set(eng_irq_set), .eng_ctx_valid(eng_ctx_valid),
    .eng_ctx_ch(eng_ctx_ch), .eng_ctx_data(eng_ctx_data), .eng_ctx_buf(eng_ctx_buf),
    .req_valid(req_valid), .req_ch(req_ch), .req_load_d(req_load_d),
    .req_start(req_start), .req_load_c(req_load_c), .req_cont(req_cont),
    .req_desc_addr(req_desc_addr), .req_ctx_addr(req_ctx_addr), .irq(irq)
  );

  function automatic logic [ADDR_W-1:0] adr(input int c, input int off);
    return ADDR_W'(c * 8192 + off);
  endfunction

  function automatic logic [31:0] stat_word(input logic [7:0] src, input logic eol,
                                            input logic [2:0] st);
    return {16'd0, src, 2'd0, eol, 2'd0, st};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // one access; outputs are sampled 1 ns after the edge that answers it
  task automatic acc(input logic wr, input logic [ADDR_W-1:0] a,
                     input logic [31:0] d, input logic [1:0] sz);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d; bus_size = sz;
    @(posedge clk);
    #1;
    bus_valid = 1'b0;
  endtask

  task automatic wr(input int c, input int off, input logic [31:0] d);
    acc(1'b1, adr(c, off), d, 2'b10);
  endtask

  task automatic rd(input int c, input int off);
    acc(1'b0, adr(c, off), 32'd0, 2'b10);
  endtask

  task automatic irq_event(input int c, input logic [IRQ_W-1:0] bits);
    @(negedge clk);
    eng_irq_set[IRQ_W*c +: IRQ_W] = bits;
    @(posedge clk);
    #1;
    eng_irq_set = '0;
  endtask

  task automatic ctx_return(input int c, input logic [31:0] d, input logic [31:0] b);
    @(negedge clk);
    eng_ctx_valid = 1'b1; eng_ctx_ch = CH_W'(c); eng_ctx_data = d; eng_ctx_buf = b;
    @(posedge clk);
    #1;
    eng_ctx_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual %h expected %h", 32'd0, 32'd1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] mdl [NUM_CH][6];
    int offs [6];
    int unused_seed;
    offs = '{'h00, 'h58, 'h5C, 'h60, 'h7C, 'h8C};
    unused_seed = $urandom(32'h5eed_1234);
    for (int c = 0; c < NUM_CH; c++)
      for (int r = 0; r < 6; r++) mdl[c][r] = '0;

    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // reset state (R3, R4)
    rd(0, 'h88);
    chk("R3 reset status", bus_rdata, stat_word(8'd0, 1'b0, 3'b001));
    chk("R6 reset irq", 32'(irq), 32'd0);
    chk("R12 ack", 32'(bus_ack), 32'd1);

    // random register traffic (R2, R1)
    for (int i = 0; i < 300; i++) begin
      int c, r;
      logic [31:0] d;
      c = int'($urandom_range(NUM_CH - 1, 0));
      r = int'($urandom_range(5, 0));
      d = $urandom();
      if ($urandom_range(1, 0) == 1) begin
        wr(c, offs[r], d);
        mdl[c][r] = (r == 5) ? (d & 32'hF) : d;
      end else begin
        rd(c, offs[r]);
        chk("R2 random readback", bus_rdata, mdl[c][r]);
      end
    end
    chk("R6 irq quiet under mask traffic", 32'(irq), 32'd0);
    rd(1, 'hA0);
    chk("R2 undefined offset", bus_rdata, 32'd0);

    // frame hole and channel isolation (R1)
    wr(2, 'h58, 32'hA5A5_0001);
    wr(1, 'h58, 32'h0000_1111);
    rd(2, 'h158);
    chk("R1 hole reads zero", bus_rdata, 32'd0);
    chk("R1 hole no error", 32'(bus_err), 32'd0);
    wr(2, 'h158, 32'h5555_5555);
    rd(2, 'h58);
    chk("R1 hole write ignored", bus_rdata, 32'hA5A5_0001);
    rd(1, 'h58);
    chk("R1 other channel kept", bus_rdata, 32'h0000_1111);

    // config state moves (R3)
    wr(2, 'h84, 32'h3);
    rd(2, 'h88);
    chk("R3 cfg 3 stopped", bus_rdata, stat_word(8'd0, 1'b0, 3'b010));
    wr(2, 'h84, 32'h1);
    rd(2, 'h88);
    chk("R3 cfg 1 keeps state", bus_rdata, stat_word(8'd0, 1'b0, 3'b010));
    wr(2, 'h84, 32'h2);
    rd(2, 'h88);
    chk("R3 cfg 2 reset wins", bus_rdata, stat_word(8'd0, 1'b0, 3'b001));
    rd(2, 'h84);
    chk("R2 cfg readback", bus_rdata, 32'h2);

    // status fields (R4)
    eng_eol[1] = 1'b1;
    eng_src[15:8] = 8'hA5;
    rd(1, 'h88);
    chk("R4 status fields", bus_rdata, stat_word(8'hA5, 1'b1, 3'b001));
    eng_eol = '0;
    eng_src = '0;

    // interrupts (R5, R6)
    wr(1, 'h8C, 32'h4);
    chk("R6 masked, nothing raw", 32'(irq), 32'd0);
    irq_event(1, 4'b0100);
    chk("R6 irq rises", 32'(irq), 32'b0010);
    irq_event(1, 4'b0001);
    rd(1, 'h94);
    chk("R5 raw bits", bus_rdata, 32'h5);
    rd(1, 'h98);
    chk("R6 masked value", bus_rdata, 32'h4);
    wr(1, 'h90, 32'h4);
    chk("R6 irq falls on ack", 32'(irq), 32'd0);
    rd(1, 'h94);
    chk("R5 ack cleared only bit 2", bus_rdata, 32'h1);
    rd(1, 'h90);
    chk("R5 ack reads zero", bus_rdata, 32'd0);
    wr(1, 'h8C, 32'h1);
    chk("R6 irq on mask write", 32'(irq), 32'b0010);
    wr(1, 'h90, 32'hF);
    chk("R6 irq cleared", 32'(irq), 32'd0);

    // stream commands (R7)
    wr(3, 'h58, 32'h0000_1000);
    wr(3, 'h9C, 32'h100);
    chk("R7 load_d req", {req_valid, req_load_d, req_start, req_load_c}, 4'b1100);
    chk("R7 req channel", 32'(req_ch), 32'd3);
    chk("R7 desc addr", req_desc_addr, 32'h0000_1000);
    rd(3, 'h00);
    chk("R7 current descriptor copied", bus_rdata, 32'h0000_1000);
    wr(3, 'h9C, 32'h020);
    chk("R7 burst alone no request", 32'(req_valid), 32'd0);
    wr(3, 'h9C, 32'h160);
    chk("R7 start req", {req_valid, req_load_d, req_start}, 3'b111);
    rd(3, 'h88);
    chk("R7 running", bus_rdata, stat_word(8'd0, 1'b0, 3'b100));

    // context load (R8)
    wr(2, 'h7C, 32'h2222_0000);
    wr(2, 'h9C, 32'h200);
    chk("R8 load_c req", {req_valid, req_load_d, req_load_c}, 3'b101);
    chk("R8 ctx addr", req_ctx_addr, 32'h2222_0000);
    ctx_return(2, 32'h0000_3333, 32'h0000_4444);
    rd(2, 'h58);
    chk("R8 ctx saved ptr", bus_rdata, 32'h0000_3333);
    rd(2, 'h5C);
    chk("R8 ctx saved buf", bus_rdata, 32'h0000_4444);

    // continue gating (R9) and invalid stores (R10)
    wr(0, 'h84, 32'h1);
    wr(0, 'h9C, 32'h160);
    eng_desc_eol[0] = 1'b0;
    wr(0, 'h80, 32'h1);
    chk("R9 no eol no continue", 32'(req_valid), 32'd0);
    eng_desc_eol[0] = 1'b1;
    wr(0, 'h80, 32'h1);
    chk("R9 continue issued", {req_valid, req_cont}, 2'b11);
    chk("R9 continue channel", 32'(req_ch), 32'd0);
    chk("R10 legal cmd", 32'(bad_store), 32'd0);
    wr(0, 'h84, 32'h3);
    wr(0, 'h80, 32'h1);
    chk("R9 stopped no continue", 32'(req_valid), 32'd0);
    wr(0, 'h80, 32'h3);
    chk("R10 cmd reserved bit", 32'(bad_store), 32'd1);
    rd(0, 'h80);
    chk("R10 value stored", bus_rdata, 32'h3);
    wr(0, 'h9C, 32'h400);
    chk("R10 stream reserved bit", 32'(bad_store), 32'd1);
    chk("R7 stream 0x400 no request", 32'(req_valid), 32'd0);
    eng_desc_eol = '0;

    // refused accesses (R11)
    acc(1'b1, adr(2, 'h58), 32'hDEAD_BEEF, 2'b00);
    chk("R11 byte write err", {bus_ack, bus_err}, 2'b11);
    acc(1'b1, adr(2, 'h9C), 32'h160, 2'b01);
    chk("R11 half write no request", {bus_err, req_valid}, 2'b10);
    rd(2, 'h58);
    chk("R11 register unchanged", bus_rdata, 32'h0000_3333);
    rd(2, 'h88);
    chk("R11 state unchanged", bus_rdata, stat_word(8'd0, 1'b0, 3'b001));
    acc(1'b0, adr(2, 'h58), 32'd0, 2'b01);
    chk("R11 half read err data", {bus_err, bus_rdata[0]}, 2'b10);
    acc(1'b0, adr(2, 'h59), 32'd0, 2'b10);
    chk("R11 misaligned err", 32'(bus_err), 32'd1);
    chk("R11 misaligned data", bus_rdata, 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule